// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block is the processor-facing register port of an eight-input interrupt controller. It watches the chip-select, read and write strobes, a single address bit and an 8-bit data bus. From these it decodes a setup sequence of up to four words, whose length depends on the first word. After setup it accepts run-time command words. It keeps every configuration field as a level output. Commands such as end-of-interrupt, priority rotation, the special-mask changes and the poll acknowledge leave the block as one-cycle pulses. The priority core and the acknowledge sequencer next to it act on these pulses.

Write strobes and bus contents are passed through a short synchronizer into the block clock. A word takes effect on the synchronized rising edge of the write strobe. The block also produces the read data. An address-high read returns the mask. An address-low read returns either the pending-request vector or the in-service vector, whichever the most recent select command chose. A poll command overrides that choice for exactly one read.

Top module: `pic_cmd_frontend`

## Requirements
- R1: A write with addr=0 and din[4]=1 is a setup-start word, accepted in any state. It captures din[3] as level_trig, din[2] as intv4, din[1] as single_mode, din[0] as need_w4 and din[7:5] as vec_lo. It drops ready and clears mask, rot_aeoi, the read select, any pending poll, cascade_map, vec_hi and all fourth-word fields.
- R2: After a start word, addr=1 writes are taken in this order. First comes the vector word, stored as vec_hi. The cascade word follows only when single_mode=0. The fourth word follows only when need_w4=1. ready rises after the last word that is due.
- R3: The cascade word is stored whole in cascade_map.
- R4: The fourth word maps din[4] to sfnm, din[3] to buffered, din[2] to master_sel, din[1] to auto_eoi and din[0] to two_pulse. These fields stay 0 when no fourth word is due.
- R5: While ready=1, an addr=1 write loads mask.
- R6: While ready=1, a write with addr=0, din[4]=0 and din[3]=0 is a priority command whose code is din[7:5]. Code 001 pulses cmd_eoi. Code 011 pulses cmd_seoi. Code 101 pulses cmd_eoi and cmd_rotate. Code 111 pulses cmd_seoi and cmd_rotate. Code 110 pulses cmd_setpri. Code 010 does nothing. With cmd_seoi or cmd_setpri, cmd_level carries din[2:0].
- R7: Priority command code 100 sets rot_aeoi and code 000 clears it.
- R8: While ready=1, a write with addr=0, din[4]=0 and din[3]=1 is a mode command. din[6:5]=11 pulses smm_set, din[6:5]=10 pulses smm_clr, and din[6]=0 pulses neither.
- R9: In a mode command with din[1]=1, din[0] selects the addr=0 read source: 0 is req_reg and 1 is isr_reg. With din[1]=0 the selection is kept. The selection holds across any number of reads. After reset or a start word the source is req_reg.
- R10: A mode command with din[2]=1 arms a poll. The next addr=0 read returns {poll_hit, 4'b0000, poll_lvl} and produces one poll_ack pulse. Later reads return the selected register again.
- R11: A read with addr=1 returns mask.
- R12: dout_en is 1 only while cs_n=0 and rd_n=0. Otherwise the data bus is released.
- R13: Writes with cs_n=1 change nothing. Priority and mode commands sent before ready=1 produce no pulse and change no state.
- R14: Every command pulse lasts exactly one clock cycle per write. A write takes effect within SYNC_STAGES+2 clock edges after wr_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the word is taken on its rise |
| addr | input | 1 | Word select address bit |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable; 0 means high impedance |
| req_reg | input | 8 | Pending-request vector from the priority core |
| isr_reg | input | 8 | In-service vector from the priority core |
| poll_hit | input | 1 | An unmasked request is waiting |
| poll_lvl | input | 3 | Level of the highest waiting request |
| ready | output | 1 | Setup sequence complete |
| level_trig | output | 1 | Level-triggered inputs selected |
| intv4 | output | 1 | Vector spacing of four selected |
| single_mode | output | 1 | Single controller, no cascade word |
| need_w4 | output | 1 | Fourth setup word expected |
| vec_lo | output | 3 | Vector bits from the start word |
| vec_hi | output | 8 | Vector word |
| cascade_map | output | 8 | Cascade word (slave map or slave identity) |
| sfnm | output | 1 | Special fully nested mode |
| buffered | output | 1 | Buffered bus mode |
| master_sel | output | 1 | Master in buffered mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| two_pulse | output | 1 | Two-pulse acknowledge mode |
| mask | output | 8 | Interrupt mask |
| rot_aeoi | output | 1 | Rotate on automatic end of interrupt |
| cmd_eoi | output | 1 | Pulse: end of interrupt, highest in service |
| cmd_seoi | output | 1 | Pulse: end of interrupt for cmd_level |
| cmd_rotate | output | 1 | Pulse: rotate along with the end of interrupt |
| cmd_setpri | output | 1 | Pulse: make cmd_level the lowest priority |
| cmd_level | output | 3 | Level that goes with cmd_seoi or cmd_setpri |
| smm_set | output | 1 | Pulse: enter special mask mode |
| smm_clr | output | 1 | Pulse: leave special mask mode |
| poll_ack | output | 1 | Pulse: a poll read was consumed |

## Verification
The assertions assume the processor never overlaps strobes. A read and a write are never active together. Each strobe stays high for at least SYNC_STAGES+1 clock cycles between accesses. Chip select, address and data stay stable for that many cycles after a write strobe rises. Under these conditions the pulse-exclusivity and poll-clearing properties hold. The bench drives every access through one write task and one read task. Each task holds the bus for several cycles around every strobe edge and leaves idle gaps between accesses, so the stimulus never leaves these conditions.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [2:0] {
    INIT_IDLE  = 3'd0,
    INIT_W2    = 3'd1,
    INIT_W3    = 3'd2,
    INIT_W4    = 3'd3,
    INIT_READY = 3'd4
  } init_st_e;

  typedef struct packed {
    logic [2:0] vec_lo;
    logic       level_trig;
    logic       intv4;
    logic       single;
    logic       need_w4;
  } w1_cfg_t;

  typedef struct packed {
    logic sfnm;
    logic buffered;
    logic master;
    logic auto_eoi;
    logic two_pulse;
  } w4_cfg_t;

  function automatic logic is_start(input logic a0, input logic [7:0] d);
    return !a0 && d[4];
  endfunction

  function automatic logic is_prio_cmd(input logic a0, input logic [7:0] d);
    return !a0 && !d[4] && !d[3];
  endfunction

  function automatic logic is_mode_cmd(input logic a0, input logic [7:0] d);
    return !a0 && !d[4] && d[3];
  endfunction

  function automatic init_st_e after_vector(input logic single, input logic need4);
    if (!single)    return INIT_W3;
    else if (need4) return INIT_W4;
    else            return INIT_READY;
  endfunction

  function automatic init_st_e after_cascade(input logic need4);
    return need4 ? INIT_W4 : INIT_READY;
  endfunction

  function automatic logic [7:0] poll_byte(input logic hit, input logic [2:0] lvl);
    return {hit, 4'b0000, lvl};
  endfunction

endpackage

// File: rtl/pic_strobe_sync.sv
module pic_strobe_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_n,
  input  logic [W-1:0] bus,
  output logic         rise,
  output logic [W-1:0] bus_q
);
  logic [STAGES-1:0] st_q;
  logic [W-1:0]      bp_q [STAGES];
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[0] <= 1'b1;
          bp_q[0] <= '1;
        end else begin
          st_q[0] <= strobe_n;
          bp_q[0] <= bus;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g] <= 1'b1;
          bp_q[g] <= '1;
        end else begin
          st_q[g] <= st_q[g-1];
          bp_q[g] <= bp_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= st_q[STAGES-1];
  end

  assign rise  = st_q[STAGES-1] & ~prev_q;
  assign bus_q = bp_q[STAGES-1];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R14

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              a0,
  input  logic [DATA_W-1:0] d,
  output logic              restart,
  output logic              ready,
  output w1_cfg_t           w1,
  output logic [DATA_W-1:0] vec_hi,
  output logic [DATA_W-1:0] casc,
  output w4_cfg_t           w4
);
  init_st_e st_q;

  assign restart = wr_fire && is_start(a0, d);
  assign ready   = (st_q == INIT_READY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= INIT_IDLE;
      w1     <= '0;
      vec_hi <= '0;
      casc   <= '0;
      w4     <= '0;
    end else if (restart) begin
      w1     <= '{vec_lo: d[7:5], level_trig: d[3], intv4: d[2],
                  single: d[1], need_w4: d[0]};
      vec_hi <= '0;
      casc   <= '0;
      w4     <= '0;
      st_q   <= INIT_W2;
    end else if (wr_fire && a0) begin
      unique case (st_q)
        INIT_W2: begin
          vec_hi <= d;
          st_q   <= after_vector(w1.single, w1.need_w4);
        end
        INIT_W3: begin
          casc <= d;
          st_q <= after_cascade(w1.need_w4);
        end
        INIT_W4: begin
          w4   <= '{sfnm: d[4], buffered: d[3], master: d[2],
                    auto_eoi: d[1], two_pulse: d[0]};
          st_q <= INIT_READY;
        end
        default: ;
      endcase
    end
  end

  AST_READY_FROM_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(st_q) == INIT_W2 || $past(st_q) == INIT_W3 ||
                      $past(st_q) == INIT_W4)); // R2
  AST_W3_ONLY_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == INIT_W3) |-> !w1.single); // R2
  AST_W4_ONLY_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == INIT_W4) |-> w1.need_w4); // R4

endmodule

// File: rtl/pic_op_cmd.sv
module pic_op_cmd
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              a0,
  input  logic [DATA_W-1:0] d,
  input  logic              restart,
  input  logic              ready,
  input  logic              rd_fire,
  input  logic              rd_a0,
  output logic [DATA_W-1:0] mask,
  output logic              rot_aeoi,
  output logic              cmd_eoi,
  output logic              cmd_seoi,
  output logic              cmd_rotate,
  output logic              cmd_setpri,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              smm_set,
  output logic              smm_clr,
  output logic              sel_isr,
  output logic              poll_pend,
  output logic              poll_ack
);
  logic op_wr;
  assign op_wr = wr_fire && ready && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask       <= '0;
      rot_aeoi   <= 1'b0;
      cmd_eoi    <= 1'b0;
      cmd_seoi   <= 1'b0;
      cmd_rotate <= 1'b0;
      cmd_setpri <= 1'b0;
      cmd_level  <= '0;
      smm_set    <= 1'b0;
      smm_clr    <= 1'b0;
      sel_isr    <= 1'b0;
      poll_pend  <= 1'b0;
      poll_ack   <= 1'b0;
    end else begin
      cmd_eoi    <= 1'b0;
      cmd_seoi   <= 1'b0;
      cmd_rotate <= 1'b0;
      cmd_setpri <= 1'b0;
      smm_set    <= 1'b0;
      smm_clr    <= 1'b0;
      poll_ack   <= 1'b0;
      if (rd_fire && !rd_a0 && poll_pend) begin
        poll_pend <= 1'b0;
        poll_ack  <= 1'b1;
      end
      if (restart) begin
        mask      <= '0;
        rot_aeoi  <= 1'b0;
        sel_isr   <= 1'b0;
        poll_pend <= 1'b0;
      end else if (op_wr) begin
        if (a0) begin
          mask <= d;
        end else if (is_prio_cmd(a0, d)) begin
          unique case (d[7:5])
            3'b001: cmd_eoi <= 1'b1;
            3'b011: begin cmd_seoi <= 1'b1; cmd_level <= d[LVL_W-1:0]; end
            3'b101: begin cmd_eoi <= 1'b1; cmd_rotate <= 1'b1; end
            3'b111: begin
              cmd_seoi   <= 1'b1;
              cmd_rotate <= 1'b1;
              cmd_level  <= d[LVL_W-1:0];
            end
            3'b110: begin cmd_setpri <= 1'b1; cmd_level <= d[LVL_W-1:0]; end
            3'b100: rot_aeoi <= 1'b1;
            3'b000: rot_aeoi <= 1'b0;
            default: ;
          endcase
        end else if (is_mode_cmd(a0, d)) begin
          smm_set <= d[6] & d[5];
          smm_clr <= d[6] & ~d[5];
          if (d[2]) poll_pend <= 1'b1;
          if (d[1]) sel_isr <= d[0];
        end
      end
    end
  end

  AST_EOI_KIND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_eoi, cmd_seoi, cmd_setpri})); // R6
  AST_ROTATE_WITH_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rotate |-> (cmd_eoi || cmd_seoi)); // R6
  AST_SMM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(smm_set && smm_clr)); // R8
  AST_CMD_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi || cmd_seoi || cmd_setpri || smm_set || smm_clr) |-> ready); // R13
  AST_POLL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |-> !poll_pend); // R10
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi || cmd_seoi) |=> !(cmd_eoi || cmd_seoi)); // R14

endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              a0,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [DATA_W-1:0] isr_reg,
  input  logic              sel_isr,
  input  logic              poll_pend,
  input  logic              poll_hit,
  input  logic [LVL_W-1:0]  poll_lvl,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  always_comb begin
    dout_en = !cs_n && !rd_n;
    if (a0)             dout = mask;
    else if (poll_pend) dout = poll_byte(poll_hit, poll_lvl);
    else if (sel_isr)   dout = isr_reg;
    else                dout = req_reg;
  end
endmodule

// File: rtl/pic_cmd_frontend.sv
module pic_cmd_frontend
  import pic_cmd_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(DATA_W),
  localparam int WBUS_W     = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [DATA_W-1:0] isr_reg,
  input  logic              poll_hit,
  input  logic [LVL_W-1:0]  poll_lvl,
  output logic              ready,
  output logic              level_trig,
  output logic              intv4,
  output logic              single_mode,
  output logic              need_w4,
  output logic [2:0]        vec_lo,
  output logic [DATA_W-1:0] vec_hi,
  output logic [DATA_W-1:0] cascade_map,
  output logic              sfnm,
  output logic              buffered,
  output logic              master_sel,
  output logic              auto_eoi,
  output logic              two_pulse,
  output logic [DATA_W-1:0] mask,
  output logic              rot_aeoi,
  output logic              cmd_eoi,
  output logic              cmd_seoi,
  output logic              cmd_rotate,
  output logic              cmd_setpri,
  output logic [LVL_W-1:0]  cmd_level,
  output logic              smm_set,
  output logic              smm_clr,
  output logic              poll_ack
);
  logic              w_rise, r_rise;
  logic [WBUS_W-1:0] w_bus;
  logic [1:0]        r_bus;
  logic              wr_fire, rd_fire, restart;
  logic              sel_isr, poll_pend;
  w1_cfg_t           w1;
  w4_cfg_t           w4;

  pic_strobe_sync #(.STAGES(SYNC_STAGES), .W(WBUS_W)) u_wsync (
    .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .bus({cs_n, addr, din}),
    .rise(w_rise), .bus_q(w_bus));

  pic_strobe_sync #(.STAGES(SYNC_STAGES), .W(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .bus({cs_n, addr}),
    .rise(r_rise), .bus_q(r_bus));

  assign wr_fire = w_rise && !w_bus[WBUS_W-1];
  assign rd_fire = r_rise && !r_bus[1];

  pic_init_seq #(.DATA_W(DATA_W)) u_init (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .a0(w_bus[DATA_W]),
    .d(w_bus[DATA_W-1:0]), .restart(restart), .ready(ready), .w1(w1),
    .vec_hi(vec_hi), .casc(cascade_map), .w4(w4));

  pic_op_cmd #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_op (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .a0(w_bus[DATA_W]),
    .d(w_bus[DATA_W-1:0]), .restart(restart), .ready(ready),
    .rd_fire(rd_fire), .rd_a0(r_bus[0]), .mask(mask), .rot_aeoi(rot_aeoi),
    .cmd_eoi(cmd_eoi), .cmd_seoi(cmd_seoi), .cmd_rotate(cmd_rotate),
    .cmd_setpri(cmd_setpri), .cmd_level(cmd_level), .smm_set(smm_set),
    .smm_clr(smm_clr), .sel_isr(sel_isr), .poll_pend(poll_pend),
    .poll_ack(poll_ack));

  pic_rd_mux #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_rd (
    .cs_n(cs_n), .rd_n(rd_n), .a0(addr), .mask(mask), .req_reg(req_reg),
    .isr_reg(isr_reg), .sel_isr(sel_isr), .poll_pend(poll_pend),
    .poll_hit(poll_hit), .poll_lvl(poll_lvl), .dout(dout), .dout_en(dout_en));

  assign level_trig  = w1.level_trig;
  assign intv4       = w1.intv4;
  assign single_mode = w1.single;
  assign need_w4     = w1.need_w4;
  assign vec_lo      = w1.vec_lo;
  assign sfnm        = w4.sfnm;
  assign buffered    = w4.buffered;
  assign master_sel  = w4.master;
  assign auto_eoi    = w4.auto_eoi;
  assign two_pulse   = w4.two_pulse;

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ready && mask == '0 && !rot_aeoi)); // R1

endmodule

// File: tb/pic_cmd_frontend_bench.sv
module pic_cmd_frontend_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en;
  logic [7:0] req_reg = 8'h3C, isr_reg = 8'h81;
  logic poll_hit = 1'b0;
  logic [2:0] poll_lvl = 3'd0;
  logic ready, level_trig, intv4, single_mode, need_w4;
  logic [2:0] vec_lo;
  logic [7:0] vec_hi, cascade_map, mask;
  logic sfnm, buffered, master_sel, auto_eoi, two_pulse, rot_aeoi;
  logic cmd_eoi, cmd_seoi, cmd_rotate, cmd_setpri, smm_set, smm_clr, poll_ack;
  logic [2:0] cmd_level;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [9:0] exp_q [$];

  always #4 clk = ~clk;

  pic_cmd_frontend u_pic_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .req_reg(req_reg), .isr_reg(isr_reg), .poll_hit(poll_hit),
    .poll_lvl(poll_lvl), .ready(ready), .level_trig(level_trig),
    .intv4(intv4), .single_mode(single_mode), .need_w4(need_w4),
    .vec_lo(vec_lo), .vec_hi(vec_hi), .cascade_map(cascade_map),
    .sfnm(sfnm), .buffered(buffered), .master_sel(master_sel),
    .auto_eoi(auto_eoi), .two_pulse(two_pulse), .mask(mask),
    .rot_aeoi(rot_aeoi), .cmd_eoi(cmd_eoi), .cmd_seoi(cmd_seoi),
    .cmd_rotate(cmd_rotate), .cmd_setpri(cmd_setpri), .cmd_level(cmd_level),
    .smm_set(smm_set), .smm_clr(smm_clr), .poll_ack(poll_ack));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected pulse item: {eoi,seoi,rotate,setpri,smm_set,smm_clr,poll_ack,level}
  task automatic expect_pulse(input logic [6:0] bits, input logic [2:0] lvl);
    exp_q.push_back({bits, lvl});
  endtask

  // scoreboard monitor: every pulse cycle pops one expected item
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] seen;
      seen = {cmd_eoi, cmd_seoi, cmd_rotate, cmd_setpri, smm_set, smm_clr, poll_ack};
      if (seen != 7'd0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R13/R14 unexpected pulse", {22'd0, seen, cmd_level}, 32'd0);
        end else begin
          logic [9:0] e;
          logic [9:0] a;
          e = exp_q.pop_front();
          a = {seen, cmd_level};
          if (!(e[8] || e[6])) begin
            a[2:0] = 3'd0;
            e[2:0] = 3'd0;
          end
          chk(a == e, "R6/R8/R10 pulse", {22'd0, a}, {22'd0, e});
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_nocs(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b1; addr = a; din = d; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] v, output logic en);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    v = dout; en = dout_en;
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    chk(!ready && mask == 8'h00 && !rot_aeoi, "R1 reset state",
        {ready, mask, rot_aeoi}, 0);
    chk(!dout_en, "R12 idle bus released", dout_en, 0);

    // setup: single, with fourth word
    wr(0, 8'hBB);
    chk({vec_lo, level_trig, intv4, single_mode, need_w4} == 7'b101_1011,
        "R1 start fields", {vec_lo, level_trig, intv4, single_mode, need_w4}, 7'b1011011);
    wr(0, 8'h20); // r13_ priority command before ready: no pulse
    chk(!ready, "R13 not ready", ready, 0);
    wr(1, 8'h40);
    chk(vec_hi == 8'h40 && !ready, "R2 vector word, no cascade word",
        {ready, vec_hi}, 9'h040);
    wr(1, 8'h1F);
    chk(ready && {sfnm, buffered, master_sel, auto_eoi, two_pulse} == 5'b11111,
        "R4 fourth word fields", {ready, sfnm, buffered, master_sel, auto_eoi, two_pulse}, 6'h3F);
    chk(cascade_map == 8'h00, "R3 cascade skipped", cascade_map, 0);
    wr(1, 8'hA5);
    chk(mask == 8'hA5, "R5 mask load", mask, 8'hA5);
    wr_nocs(1, 8'hFF);
    chk(mask == 8'hA5, "R13 deselected write ignored", mask, 8'hA5);
    rd(1, v, en);
    chk(v == 8'hA5 && en, "R11 mask read", {en, v}, 9'h1A5);

    // priority commands
    expect_pulse(7'b1000000, 3'd0); wr(0, 8'h20);
    expect_pulse(7'b0100000, 3'd5); wr(0, 8'h65);
    expect_pulse(7'b1010000, 3'd0); wr(0, 8'hA0);
    expect_pulse(7'b0110000, 3'd2); wr(0, 8'hE2);
    expect_pulse(7'b0001000, 3'd6); wr(0, 8'hC6);
    wr(0, 8'h40); // code 010: nothing
    wr(0, 8'h80);
    chk(rot_aeoi, "R7 rotate-in-auto set", rot_aeoi, 1);
    wr(0, 8'h00);
    chk(!rot_aeoi, "R7 rotate-in-auto clear", rot_aeoi, 0);

    // mode commands
    expect_pulse(7'b0000100, 3'd0); wr(0, 8'h68);
    expect_pulse(7'b0000010, 3'd0); wr(0, 8'h48);
    wr(0, 8'h28); // din[6]=0: no pulse

    // read select
    rd(0, v, en);
    chk(v == 8'h3C, "R9 default request read", v, 8'h3C);
    wr(0, 8'h0B);
    rd(0, v, en);
    chk(v == 8'h81, "R9 in-service read", v, 8'h81);
    rd(0, v, en);
    chk(v == 8'h81, "R9 selection persists", v, 8'h81);
    wr(0, 8'h09);
    rd(0, v, en);
    chk(v == 8'h81, "R9 no-change select", v, 8'h81);
    wr(0, 8'h0A);
    rd(0, v, en);
    chk(v == 8'h3C, "R9 back to request", v, 8'h3C);

    // poll
    poll_hit = 1'b1; poll_lvl = 3'd5;
    expect_pulse(7'b0000001, 3'd0); wr(0, 8'h0C);
    rd(0, v, en);
    chk(v == 8'h85, "R10 poll byte", v, 8'h85);
    rd(0, v, en);
    chk(v == 8'h3C, "R10 poll only once", v, 8'h3C);
    poll_hit = 1'b0; poll_lvl = 3'd3;
    expect_pulse(7'b0000001, 3'd0); wr(0, 8'h0C);
    rd(0, v, en);
    chk(v == 8'h03, "R10 poll with no request", v, 8'h03);

    // bus release
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk(!dout_en, "R12 released without select", dout_en, 0);
    rd_n = 1'b1; cs_n = 1'b0;
    @(negedge clk);
    chk(!dout_en, "R12 released without read", dout_en, 0);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);

    // restart from ready
    wr(0, 8'h80);
    wr(0, 8'h0B);
    wr(0, 8'h11);
    chk(!ready && mask == 8'h00 && !rot_aeoi && two_pulse == 1'b0,
        "R1 restart clears", {ready, mask, rot_aeoi, two_pulse}, 0);
    rd(0, v, en);
    chk(v == 8'h3C, "R1 restart resets read select", v, 8'h3C);
    wr(1, 8'h08);
    chk(!ready, "R2 cascade word due", ready, 0);
    wr(1, 8'h84);
    chk(cascade_map == 8'h84 && !ready, "R3 cascade word", {ready, cascade_map}, 9'h084);
    wr(1, 8'h01);
    chk(ready && two_pulse && !sfnm && !auto_eoi, "R4 two-pulse only",
        {ready, sfnm, buffered, master_sel, auto_eoi, two_pulse}, 6'h21);

    // cascade, no fourth word
    wr(0, 8'h10);
    wr(1, 8'h08);
    wr(1, 8'h02);
    chk(ready && cascade_map == 8'h02 && !two_pulse, "R2 cascade then ready",
        {ready, cascade_map, two_pulse}, 10'h204);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R14 all pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule